// File: doc/BRIEF.md
# Neighbour-Linked Address March Self-Test

This engine tests a single-port synchronous RAM for faults that a plain write-then-read pass misses. These are address lines that decode two locations onto one cell, and cells that disturb their neighbour when they change. After a `start` pulse it fills every location with a background chosen by a static 2-bit mode input. It then walks a pointer from the lowest address to the highest. At each location it confirms that the cell and its upper neighbour still hold the background. It then writes the complement of the background into the cell and confirms both locations again. A neighbour that follows the write therefore shows up as a mismatch.

The first mismatch ends the run. The engine then raises `fail` together with `done`, and it holds the failing address, the expected word and the word read back until the next start. A clean run ends with `done` high and `fail` low. The RAM is expected to return read data on the cycle after a read request.

Top module: `nbr_march_bist`

## Requirements
- R1: After reset, `busy`, `done`, `fail` and `mem_en` are all low, and no memory request is issued while `busy` is low.
- R2: A start taken while idle or done begins a fill phase that writes one location per cycle, from address 0 up to DEPTH-1.
- R3: Background encoding by `bg_mode`: 00 writes all zeros, 01 writes all ones, 10 writes 0xAA.. (every odd bit set) at even addresses and 0x55.. at odd addresses, and 11 writes the opposite checkerboard.
- R4: For each address i below DEPTH-1 the march issues, on consecutive cycles, the following requests: read i, read i+1, write the complement of i's background to i, read i, read i+1.
- R5: At address DEPTH-1 both neighbour reads are skipped, so the step there is read, write complement, read.
- R6: A clean run keeps `busy` high for exactly 6*DEPTH-1 cycles, then shows `done` high and `fail` low; `done` and `busy` are never high together.
- R7: Read data is compared in the cycle after its request. After the request that exposes a fault, `fail` rises with exactly one further cycle of `busy`.
- R8: A mismatch raises `fail` and `done` in the same cycle. It latches the address, expected word and actual word, issues no further memory requests and holds the latched values until the next start.
- R9: A new start clears `fail` on the clock edge that accepts it.
- R10: A start pulse during a run has no effect: the request stream and the run length are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a run when idle or done |
| bg_mode | input | 2 | Background select, static during a run |
| mem_en | output | 1 | RAM request strobe |
| mem_we | output | 1 | RAM write enable (read when low) |
| mem_addr | output | AW | RAM address |
| mem_wdata | output | DW | RAM write data |
| mem_rdata | input | DW | RAM read data, one cycle after a read request |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished (clean or failed) |
| fail | output | 1 | A mismatch was found |
| fail_addr | output | AW | Address of the mismatching read |
| fail_exp | output | DW | Word that was expected |
| fail_act | output | DW | Word that was read |

## Verification
Requests are due one per cycle, starting in the first cycle after the edge that accepts `start`. A scoreboard queue holds the predicted stream and pops one entry in every cycle where `mem_en` is high, sampling at the falling edge. A clean run must leave `busy` high for 6*DEPTH-1 falling-edge samples. With an injected fault, `busy` must drop exactly two cycles after the exposing read request, and that count is checked against the cycle computed by hand for each fault. `fail` must already be clear at the first sample after a restart.

// File: rtl/nbr_march_pkg.sv
package nbr_march_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_FILL, ST_MARCH, ST_DRAIN, ST_DONE
   } st_t;

   typedef enum logic [2:0] {
      PH_RD_CUR, PH_RD_NXT, PH_WR_CUR, PH_RE_CUR, PH_RE_NXT
   } ph_t;

   typedef enum logic [1:0] {
      BG_ZERO = 2'b00, BG_ONE = 2'b01, BG_CHK = 2'b10, BG_CHKN = 2'b11
   } bg_t;
endpackage

// File: rtl/nbr_march_bg.sv
module nbr_march_bg
   import nbr_march_pkg::*;
#(
   parameter int DW     = 8,
   parameter bit CHK_EN = 1'b1
) (
   input  logic [1:0]    mode,
   input  logic          addr_lsb,
   input  logic          inv,
   output logic [DW-1:0] pat
);
   logic [DW-1:0] chk;
   logic [DW-1:0] base;

   generate
      if (CHK_EN) begin : g_chk
         for (genvar g = 0; g < DW; g++) begin : g_bit
            assign chk[g] = ((g % 2) == 1);
         end
      end else begin : g_nochk
         assign chk = '0;
      end
   endgenerate

   always_comb begin
      case (bg_t'(mode))
         BG_ZERO: base = '0;
         BG_ONE:  base = '1;
         BG_CHK:  base = addr_lsb ? ~chk : chk;
         default: base = addr_lsb ? chk : ~chk;
      endcase
      pat = base ^ {DW{inv}};
   end
endmodule

// File: rtl/nbr_march_seq.sv
module nbr_march_seq
   import nbr_march_pkg::*;
#(
   parameter int AW    = 4,
   parameter int DEPTH = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          mismatch,
   output logic          req_en,
   output logic          req_we,
   output logic [AW-1:0] req_addr,
   output logic          req_inv,
   output logic          busy,
   output logic          done
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   st_t           st;
   ph_t           ph;
   logic [AW-1:0] ptr;
   logic [AW-1:0] ptr_nxt;
   logic          at_last;

   assign ptr_nxt = ptr + 1'b1;
   assign at_last = (ptr == LAST);
   assign busy    = (st == ST_FILL) || (st == ST_MARCH) || (st == ST_DRAIN);
   assign done    = (st == ST_DONE);

   always_comb begin
      req_en   = 1'b0;
      req_we   = 1'b0;
      req_addr = ptr;
      req_inv  = 1'b0;
      if (st == ST_FILL) begin
         req_en = 1'b1;
         req_we = 1'b1;
      end else if (st == ST_MARCH) begin
         req_en = 1'b1;
         case (ph)
            PH_RD_NXT: req_addr = ptr_nxt;
            PH_WR_CUR: begin req_we = 1'b1; req_inv = 1'b1; end
            PH_RE_CUR: req_inv = 1'b1;
            PH_RE_NXT: req_addr = ptr_nxt;
            default:   ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_IDLE;
         ph  <= PH_RD_CUR;
         ptr <= '0;
      end else begin
         case (st)
            ST_IDLE, ST_DONE: if (start) begin
               st  <= ST_FILL;
               ph  <= PH_RD_CUR;
               ptr <= '0;
            end
            ST_FILL: begin
               ptr <= at_last ? '0 : ptr_nxt;
               if (at_last) st <= ST_MARCH;
            end
            ST_MARCH: begin
               if (mismatch) st <= ST_DONE;
               else begin
                  case (ph)
                     PH_RD_CUR: ph <= at_last ? PH_WR_CUR : PH_RD_NXT;
                     PH_RD_NXT: ph <= PH_WR_CUR;
                     PH_WR_CUR: ph <= PH_RE_CUR;
                     PH_RE_CUR: if (at_last) st <= ST_DRAIN;
                                else         ph <= PH_RE_NXT;
                     default: begin
                        ph  <= PH_RD_CUR;
                        ptr <= ptr_nxt;
                     end
                  endcase
               end
            end
            ST_DRAIN: st <= ST_DONE;
            default:  st <= ST_IDLE;
         endcase
      end
   end

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !req_en);

   assert_addr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_en |-> (int'(req_addr) < DEPTH));

   assert_fill_ascends_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FILL && !at_last) |=> (st == ST_FILL && ptr == AW'($past(ptr) + 1'b1)));

   assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (start && (st == ST_FILL || st == ST_MARCH) && !mismatch) |=> busy);
endmodule

// File: rtl/nbr_march_cmp.sv
module nbr_march_cmp #(
   parameter int AW = 4,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          rd_issue,
   input  logic [AW-1:0] rd_addr,
   input  logic [DW-1:0] rd_exp,
   input  logic [DW-1:0] rdata,
   output logic          mismatch,
   output logic          fail,
   output logic [AW-1:0] fail_addr,
   output logic [DW-1:0] fail_exp,
   output logic [DW-1:0] fail_act
);
   logic          pend_vld;
   logic [AW-1:0] pend_addr;
   logic [DW-1:0] pend_exp;

   assign mismatch = pend_vld && !fail && (rdata != pend_exp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_vld  <= 1'b0;
         pend_addr <= '0;
         pend_exp  <= '0;
         fail      <= 1'b0;
         fail_addr <= '0;
         fail_exp  <= '0;
         fail_act  <= '0;
      end else begin
         pend_vld  <= rd_issue;
         pend_addr <= rd_addr;
         pend_exp  <= rd_exp;
         if (clear) begin
            fail <= 1'b0;
         end else if (mismatch) begin
            fail      <= 1'b1;
            fail_addr <= pend_addr;
            fail_exp  <= pend_exp;
            fail_act  <= rdata;
         end
      end
   end

   assert_fail_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && !clear) |=> (fail && $stable(fail_addr) && $stable(fail_exp) && $stable(fail_act)));

   assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !fail);
endmodule

// File: rtl/nbr_march_bist.sv
module nbr_march_bist
   import nbr_march_pkg::*;
#(
   parameter int AW     = 4,
   parameter int DEPTH  = 16,
   parameter int DW     = 8,
   parameter bit CHK_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [1:0]    bg_mode,
   output logic          mem_en,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic          busy,
   output logic          done,
   output logic          fail,
   output logic [AW-1:0] fail_addr,
   output logic [DW-1:0] fail_exp,
   output logic [DW-1:0] fail_act
);
   generate
      if (DEPTH < 2 || DEPTH > (1 << AW)) begin : g_bad_depth
         $error("DEPTH must lie in 2 .. 2**AW");
      end
      if (DW < 1) begin : g_bad_dw
         $error("DW must be at least 1");
      end
   endgenerate

   logic          req_inv;
   logic          mismatch;
   logic [DW-1:0] pat;

   nbr_march_seq #(.AW(AW), .DEPTH(DEPTH)) seq_i (
      .clk(clk), .rst_n(rst_n), .start(start), .mismatch(mismatch),
      .req_en(mem_en), .req_we(mem_we), .req_addr(mem_addr), .req_inv(req_inv),
      .busy(busy), .done(done)
   );

   nbr_march_bg #(.DW(DW), .CHK_EN(CHK_EN)) bg_i (
      .mode(bg_mode), .addr_lsb(mem_addr[0]), .inv(req_inv), .pat(pat)
   );

   assign mem_wdata = pat;

   nbr_march_cmp #(.AW(AW), .DW(DW)) cmp_i (
      .clk(clk), .rst_n(rst_n), .clear(start && !busy),
      .rd_issue(mem_en && !mem_we), .rd_addr(mem_addr), .rd_exp(pat),
      .rdata(mem_rdata), .mismatch(mismatch),
      .fail(fail), .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_act(fail_act)
   );

   assert_fail_ends_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fail) |-> done);

   assert_quiet_after_fail_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> !mem_en);

   assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && busy));
endmodule

// File: tb/nbr_march_bist_tb_top.sv
`timescale 1ns/1ps
module nbr_march_bist_tb_top;
   localparam int AW = 4;
   localparam int DEPTH = 16;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [1:0]    bg_mode = 2'b00;
   logic          mem_en, mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata = '0;
   logic          busy, done, fail;
   logic [AW-1:0] fail_addr;
   logic [DW-1:0] fail_exp, fail_act;

   always #2.5 clk = ~clk;

   nbr_march_bist #(.AW(AW), .DEPTH(DEPTH), .DW(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .bg_mode(bg_mode),
      .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .busy(busy), .done(done), .fail(fail),
      .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_act(fail_act)
   );

   // RAM model with optional faults: address 6 aliased onto 5, bit 0 of cell 3 stuck low
   logic [DW-1:0] ram [DEPTH];
   bit alias_en = 0;
   bit stuck_en = 0;

   always @(posedge clk) begin
      if (mem_en) begin
         int a;
         a = int'(mem_addr);
         if (alias_en && a == 6) a = 5;
         if (mem_we) ram[a] <= mem_wdata;
         else        mem_rdata <= (stuck_en && a == 3) ? (ram[a] & 8'hFE) : ram[a];
      end
   end

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   task automatic check(bit ok, string req, string what, int act, int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   function automatic logic [7:0] bg(logic [1:0] m, int a);
      case (m)
         2'b00:   return 8'h00;
         2'b01:   return 8'hFF;
         2'b10:   return a[0] ? 8'h55 : 8'hAA;
         default: return a[0] ? 8'hAA : 8'h55;
      endcase
   endfunction

   typedef struct {
      bit         we;
      int         a;
      logic [7:0] d;
      string      tag;
   } op_t;

   op_t exp_q[$];
   bit  sb_on = 0;
   int  req_during_fail = 0;

   task automatic push_op(bit we, int a, logic [7:0] d, string tag);
      op_t o;
      o.we = we; o.a = a; o.d = d; o.tag = tag;
      exp_q.push_back(o);
   endtask

   // driver: predicted request stream for one clean run
   task automatic push_run(logic [1:0] m);
      for (int a = 0; a < DEPTH; a++) push_op(1, a, bg(m, a), "R2 R3");
      for (int i = 0; i < DEPTH; i++) begin
         string t;
         t = (i == DEPTH - 1) ? "R5" : "R4";
         push_op(0, i, 8'h00, t);
         if (i < DEPTH - 1) push_op(0, i + 1, 8'h00, t);
         push_op(1, i, ~bg(m, i), t);
         push_op(0, i, 8'h00, t);
         if (i < DEPTH - 1) push_op(0, i + 1, 8'h00, t);
      end
   endtask

   // monitor: pops one predicted request per observed request
   always @(negedge clk) begin
      if (rst_n && fail && mem_en) req_during_fail++;
      if (sb_on && mem_en) begin
         if (exp_q.size() == 0) begin
            check(0, "R4", "unexpected request addr", int'(mem_addr), -1);
         end else begin
            op_t o;
            bit ok;
            o = exp_q.pop_front();
            ok = (mem_we == o.we) && (int'(mem_addr) == o.a) && (!o.we || mem_wdata == o.d);
            check(ok, o.tag, "request {we,addr,data}",
                  {mem_we, 4'(mem_addr), mem_wdata}, {o.we, 4'(o.a), (o.we ? o.d : mem_wdata)});
         end
      end
   end

   // one run; returns number of busy samples; optional mid-run start pulse
   task automatic run(logic [1:0] m, bit sb, int poke_at, output int cnt);
      bg_mode = m;
      exp_q.delete();
      if (sb) push_run(m);
      sb_on = sb;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(fail == 1'b0, "R9", "fail after restart", fail, 0);
      cnt = 0;
      while (busy) begin
         cnt++;
         start = (cnt == poke_at);
         @(negedge clk);
      end
      start = 1'b0;
      sb_on = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int cnt;
      repeat (3) @(negedge clk);
      check(!busy && !done && !fail && !mem_en, "R1", "outputs in reset",
            {busy, done, fail, mem_en}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !done && !mem_en, "R1", "idle after reset", {busy, done, mem_en}, 0);

      for (int m = 0; m < 4; m++) begin
         run(2'(m), 1, (m == 2) ? 20 : 0, cnt);
         check(cnt == 6 * DEPTH - 1, "R6", "busy cycles", cnt, 6 * DEPTH - 1);
         check(done && !fail, "R6", "clean completion {done,fail}", {done, fail}, 2);
         check(exp_q.size() == 0, (m == 2) ? "R10" : "R4", "requests left", exp_q.size(), 0);
      end

      stuck_en = 1;
      run(2'b01, 0, 0, cnt);
      check(cnt == 29, "R7", "busy cycles to stuck-bit fail", cnt, 29);
      check(done && fail, "R8", "{done,fail}", {done, fail}, 3);
      check(fail_addr == 3, "R8", "fail_addr", fail_addr, 3);
      check(fail_exp == 8'hFF && fail_act == 8'hFE, "R8", "exp/act",
            {fail_exp, fail_act}, 16'hFFFE);
      stuck_en = 0;

      alias_en = 1;
      run(2'b00, 0, 0, cnt);
      check(cnt == 47, "R7", "busy cycles to alias fail", cnt, 47);
      check(fail && fail_addr == 6, "R8", "alias fail_addr", fail_addr, 6);
      check(fail_exp == 8'h00 && fail_act == 8'hFF, "R8", "alias exp/act",
            {fail_exp, fail_act}, 16'h00FF);
      repeat (4) @(negedge clk);
      check(fail && fail_addr == 6 && !mem_en, "R8", "fail held, bus quiet", fail_addr, 6);
      check(req_during_fail == 0, "R8", "requests while fail", req_during_fail, 0);
      alias_en = 0;

      run(2'b10, 1, 0, cnt);
      check(cnt == 6 * DEPTH - 1 && !fail, "R9", "clean rerun after fail", cnt, 6 * DEPTH - 1);

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule